// File: doc/BRIEF.md
# Multi-Sensor Thermal and Power Protection Controller

This block watches a set of digitized sensor readings (rail power, rail current and several temperatures) and decides when the accelerator must protect itself. It has three escalating actions. The first slows the kernel clocks (throttle). The second stops the kernel clocks and raises a one-cycle bus-fault trip (clock stop). The third asks for power to the main device to be removed (power off). Each sensor has one threshold per tier, and each threshold carries an enable bit. A cleared enable bit marks a sensor that is exempt from that tier.

The tiers recover in different ways. Throttle follows the most recent samples: it is held while any sensor sits at or above its throttle limit, and it clears once every sensor is back below. Clock stop is held until the host issues a reset request. Power off is held until a power-on reset. A sticky map records, for each tier, which sensors have reached that tier's limit.

The controller is a four-state machine:
- ST_RUN is the normal state.
- ST_THROTTLE is the throttled state.
- ST_STOP means the clocks are stopped.
- ST_OFF means power is removed.

The transitions are:
- Any state other than ST_OFF moves to ST_OFF when a power-off hit is present.
- ST_RUN and ST_THROTTLE move to ST_RUN when the host reset request is high.
- Otherwise, ST_RUN and ST_THROTTLE move to ST_STOP on a clock-stop hit, to ST_THROTTLE on a throttle hit, and to ST_RUN when there is no hit.
- ST_STOP moves to ST_RUN on a host reset request and otherwise stays in ST_STOP.
- ST_OFF stays in ST_OFF until the power-on reset.

Top module: `tp_guard`

## Requirements
- R1: A tier triggers for a sensor when that sensor's sampled reading is greater than or equal to its threshold for the tier. A reading one below the threshold does not trigger that tier.
- R2: throttle_req is high while any sensor's latest sample is at or above its throttle threshold. It falls only when every sensor's latest sample is strictly below its throttle threshold.
- R3: A clock-stop hit raises kclk_stop. kclk_stop then stays high, whatever later samples show, until host_rst is seen. fw_trip is high for exactly one cycle on entry to clock stop and does not repeat while the state is held.
- R4: A power-off hit raises pwr_off. pwr_off is held and ignores host_rst; only rst_n clears it. Entering power off never produces an fw_trip pulse.
- R5: Priority is power off, then clock stop, then throttle. While pwr_off is high, kclk_stop and throttle_req are forced high and fw_trip is low. While kclk_stop is high, throttle_req is forced high.
- R6: A threshold whose enable bit is 0 never triggers its tier, whatever the reading. The enable bit for tier t (0 = throttle, 1 = clock stop, 2 = power off) of sensor s is thr_en[t*N+s], and its threshold value is thr_val[(t*N+s)*W +: W].
- R7: Readings are compared only on cycles where the sensor's rd_valid bit is high. A reading that changes without the strobe has no effect, and a sensor that has had no valid sample since reset, or since the last host reset, cannot trigger any tier.
- R8: The bit trip_map[t*N+s] is set when sensor s reaches tier t, and it stays set. host_rst clears the throttle and clock-stop bits and the stored samples, except while powered off. The power-off bits clear only on rst_n.
- R9: An output reacts on the clock edge after the edge that captured the sample. host_rst takes effect on the edge that captures it.
- R10: After rst_n, all outputs are low and trip_map is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset; the only way out of power off |
| host_rst | input | 1 | Host reset request; ends clock stop and clears the stored samples |
| rd_valid | input | N | Per-sensor sample strobe |
| rd_value | input | N*W | Sensor readings; sensor s is in bits s*W +: W |
| thr_val | input | 3*N*W | Thresholds; tier t of sensor s is in bits (t*N+s)*W +: W |
| thr_en | input | 3*N | Threshold enables; tier t of sensor s is bit t*N+s |
| throttle_req | output | 1 | Request to lower the kernel clock frequency |
| kclk_stop | output | 1 | Kernel clock gate disable |
| fw_trip | output | 1 | One-cycle bus-fault trip pulse |
| pwr_off | output | 1 | Request to remove power from the main device |
| trip_map | output | 3*N | Sticky record of tripped sensors per tier, same indexing as thr_en |

## Verification
The bench sweeps every enabled threshold of the six-sensor set at the threshold value and at one below it. An off-by-one (strict) comparison would miss the exact-threshold point, and a comparison against the wrong tier or sensor would set a wrong trip_map bit. The bench checks that throttle is held while one of two sensors is still hot, so a design that releases on the first cool sensor fails. It checks that clock stop survives a cooled sample and that power off survives host_rst; a design with a wrong release rule would drop these states early. It also checks that fw_trip lasts one cycle and does not appear on a direct entry to power off, that a disabled threshold stays silent, and that a reading with no strobe changes nothing.

// File: rtl/tp_pkg.sv
package tp_pkg;
    localparam int TIERS     = 3;
    localparam int TIER_THR  = 0;
    localparam int TIER_STOP = 1;
    localparam int TIER_OFF  = 2;

    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_THROTTLE = 2'd1,
        ST_STOP     = 2'd2,
        ST_OFF      = 2'd3
    } tp_state_e;
endpackage

// File: rtl/tp_sense.sv
// Holds the tier hits of one sensor, refreshed only on its sample strobe.
module tp_sense #(
    parameter int W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     valid,
    input  logic [W-1:0]             value,
    input  logic [tp_pkg::TIERS*W-1:0] thr,
    input  logic [tp_pkg::TIERS-1:0] en,
    output logic [tp_pkg::TIERS-1:0] hit
);
    for (genvar t = 0; t < tp_pkg::TIERS; t++) begin : g_tier
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                hit[t] <= 1'b0;
            else if (clr)
                hit[t] <= 1'b0;
            else if (valid)
                hit[t] <= en[t] && (value >= thr[t*W +: W]);
        end
    end
endmodule

// File: rtl/tp_fsm.sv
module tp_fsm
    import tp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic host_rst,
    input  logic any_thr,
    input  logic any_stop,
    input  logic any_off,
    output logic clr,
    output logic throttle_req,
    output logic kclk_stop,
    output logic pwr_off,
    output logic fw_trip
);
    tp_state_e state, nxt;
    logic      trip_q;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN, ST_THROTTLE: begin
                if (any_off)       nxt = ST_OFF;
                else if (host_rst) nxt = ST_RUN;
                else if (any_stop) nxt = ST_STOP;
                else if (any_thr)  nxt = ST_THROTTLE;
                else               nxt = ST_RUN;
            end
            ST_STOP: begin
                if (any_off)       nxt = ST_OFF;
                else if (host_rst) nxt = ST_RUN;
                else               nxt = ST_STOP;
            end
            ST_OFF: nxt = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_RUN;
            trip_q <= 1'b0;
        end else begin
            state  <= nxt;
            trip_q <= (nxt == ST_STOP) && (state != ST_STOP);
        end
    end

    always_comb begin
        throttle_req = 1'b0;
        kclk_stop    = 1'b0;
        pwr_off      = 1'b0;
        unique case (state)
            ST_RUN:      ;
            ST_THROTTLE: throttle_req = 1'b1;
            ST_STOP: begin
                throttle_req = 1'b1;
                kclk_stop    = 1'b1;
            end
            ST_OFF: begin
                throttle_req = 1'b1;
                kclk_stop    = 1'b1;
                pwr_off      = 1'b1;
            end
        endcase
        fw_trip = trip_q;
        clr     = host_rst && (state != ST_OFF);
    end
endmodule

// File: rtl/tp_status.sv
// Sticky per-tier, per-sensor record; host clear spares the power-off tier.
module tp_status #(
    parameter int N = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic [tp_pkg::TIERS*N-1:0] hits,
    output logic [tp_pkg::TIERS*N-1:0] map
);
    localparam int HOSTCLR = tp_pkg::TIER_OFF * N;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            map <= '0;
        end else begin
            map[tp_pkg::TIER_OFF*N +: N] <= map[tp_pkg::TIER_OFF*N +: N]
                                          | hits[tp_pkg::TIER_OFF*N +: N];
            if (clr)
                map[HOSTCLR-1:0] <= '0;
            else
                map[HOSTCLR-1:0] <= map[HOSTCLR-1:0] | hits[HOSTCLR-1:0];
        end
    end
endmodule

// File: rtl/tp_guard.sv
module tp_guard #(
    parameter int N = 6,
    parameter int W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          host_rst,
    input  logic [N-1:0]                  rd_valid,
    input  logic [N*W-1:0]                rd_value,
    input  logic [tp_pkg::TIERS*N*W-1:0]  thr_val,
    input  logic [tp_pkg::TIERS*N-1:0]    thr_en,
    output logic                          throttle_req,
    output logic                          kclk_stop,
    output logic                          fw_trip,
    output logic                          pwr_off,
    output logic [tp_pkg::TIERS*N-1:0]    trip_map
);
    import tp_pkg::*;

    logic [N-1:0][TIERS*W-1:0] s_thr;
    logic [N-1:0][TIERS-1:0]   s_en;
    logic [N-1:0][TIERS-1:0]   s_hit;
    logic [TIERS*N-1:0]        hits;
    logic                      clr;

    for (genvar s = 0; s < N; s++) begin : g_sens
        for (genvar t = 0; t < TIERS; t++) begin : g_map
            assign s_thr[s][t*W +: W] = thr_val[(t*N+s)*W +: W];
            assign s_en[s][t]         = thr_en[t*N+s];
            assign hits[t*N+s]        = s_hit[s][t];
        end
        tp_sense #(.W(W)) u_sense (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .valid (rd_valid[s]),
            .value (rd_value[s*W +: W]),
            .thr   (s_thr[s]),
            .en    (s_en[s]),
            .hit   (s_hit[s])
        );
    end

    tp_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_rst     (host_rst),
        .any_thr      (|hits[TIER_THR*N  +: N]),
        .any_stop     (|hits[TIER_STOP*N +: N]),
        .any_off      (|hits[TIER_OFF*N  +: N]),
        .clr          (clr),
        .throttle_req (throttle_req),
        .kclk_stop    (kclk_stop),
        .pwr_off      (pwr_off),
        .fw_trip      (fw_trip)
    );

    tp_status #(.N(N)) u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .hits  (hits),
        .map   (trip_map)
    );
endmodule

// File: rtl/tp_guard_chk.sv
module tp_guard_chk #(
    parameter int N = 6
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       host_rst,
    input logic                       throttle_req,
    input logic                       kclk_stop,
    input logic                       fw_trip,
    input logic                       pwr_off,
    input logic [tp_pkg::TIERS*N-1:0] trip_map
);
    localparam int OFFB = tp_pkg::TIER_OFF * N;

    a_r3_trip_single: assert property (@(posedge clk) disable iff (!rst_n)
        fw_trip |=> !fw_trip);
    a_r3_stop_held: assert property (@(posedge clk) disable iff (!rst_n)
        (kclk_stop && !host_rst) |=> kclk_stop);
    a_r3_trip_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(kclk_stop) && !pwr_off) |-> fw_trip);
    a_r4_off_held: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_off |=> pwr_off);
    a_r4_no_trip_off: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_off |-> !fw_trip);
    a_r5_off_forces: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_off |-> (kclk_stop && throttle_req));
    a_r5_stop_forces: assert property (@(posedge clk) disable iff (!rst_n)
        kclk_stop |-> throttle_req);
    a_r8_off_map_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (|trip_map[OFFB +: N]) |=> (|trip_map[OFFB +: N]));
endmodule

bind tp_guard tp_guard_chk #(.N(N)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_rst     (host_rst),
    .throttle_req (throttle_req),
    .kclk_stop    (kclk_stop),
    .fw_trip      (fw_trip),
    .pwr_off      (pwr_off),
    .trip_map     (trip_map)
);

// File: tb/tp_guard_tb.sv
module tp_guard_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 6;
    localparam int W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             host_rst = 1'b0;
    logic [N-1:0]     rd_valid = '0;
    logic [N*W-1:0]   rd_value = '0;
    logic [3*N*W-1:0] thr_val;
    logic [3*N-1:0]   thr_en;
    logic             throttle_req, kclk_stop, fw_trip, pwr_off;
    logic [3*N-1:0]   trip_map;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 0;

    // sensors: 0 12V power (0.1 W), 1 3V3 power (0.1 W), 2 core current (mA),
    // 3 core temp, 4 die/memory temp, 5 optical temp; tiers throttle/stop/off
    int thr_tab [N][3] = '{'{620, 650, 0}, '{99, 110, 0}, '{56000, 0, 60000},
                           '{0, 110, 125}, '{92, 97, 107}, '{0, 85, 90}};
    bit en_tab  [N][3] = '{'{1, 1, 0}, '{1, 1, 0}, '{1, 0, 1},
                           '{0, 1, 1}, '{1, 1, 1}, '{0, 1, 1}};

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int s = 0; s < N; s++)
            for (int t = 0; t < 3; t++) begin
                thr_val[(t*N+s)*W +: W] = thr_tab[s][t][W-1:0];
                thr_en[t*N+s]           = en_tab[s][t];
            end
    end

    tp_guard #(.N(N), .W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_rst(host_rst),
        .rd_valid(rd_valid), .rd_value(rd_value),
        .thr_val(thr_val), .thr_en(thr_en),
        .throttle_req(throttle_req), .kclk_stop(kclk_stop),
        .fw_trip(fw_trip), .pwr_off(pwr_off), .trip_map(trip_map)
    );

    function automatic int bp(int t, int s);
        return t*N + s;
    endfunction

    task automatic chk(string req, bit et, bit es, bit eo, bit ef,
                       logic [3*N-1:0] em);
        logic [3*N+3:0] act, exp;
        act = {throttle_req, kclk_stop, pwr_off, fw_trip, trip_map};
        exp = {et, es, eo, ef, em};
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: thr/stop/off/trip/map actual %b expected %b",
                     req, act, exp);
        end
    endtask

    task automatic por();
        @(negedge clk);
        rst_n = 1'b0; rd_valid = '0; host_rst = 1'b0; rd_value = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // drive one strobed sample; returns at the first point the result is visible
    task automatic samp(int s, int v);
        @(negedge clk);
        rd_value[s*W +: W] = v[W-1:0];
        rd_valid[s] = 1'b1;
        @(negedge clk);
        rd_valid = '0;
        @(negedge clk);
    endtask

    task automatic hreset();
        @(negedge clk);
        host_rst = 1'b1;
        @(negedge clk);
        host_rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD*100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [3*N-1:0] em;
        por();
        chk("R10 reset state", 0, 0, 0, 0, '0);

        // R7: reading above every limit without a strobe does nothing
        rd_value[4*W +: W] = 16'd200;
        repeat (4) @(negedge clk);
        chk("R7 no strobe", 0, 0, 0, 0, '0);
        samp(4, 10);
        chk("R7 cool strobed sample", 0, 0, 0, 0, '0);

        // R1/R6: sweep each enabled threshold at limit-1 and at the limit
        for (int s = 0; s < N; s++)
            for (int t = 0; t < 3; t++)
                if (en_tab[s][t])
                    for (int d = -1; d <= 0; d++) begin
                        int v; int top;
                        v = thr_tab[s][t] + d;
                        por();
                        samp(s, v);
                        em = '0; top = -1;
                        for (int t2 = 0; t2 < 3; t2++)
                            if (en_tab[s][t2] && v >= thr_tab[s][t2]) begin
                                em[bp(t2, s)] = 1'b1; top = t2;
                            end
                        chk(d == 0 ? "R1 at threshold" : "R1 one below", top >= 0,
                            top >= 1, top == 2, top == 1, em);
                    end

        // R6: full-scale reading sets only enabled tiers
        por();
        samp(0, 65535);
        chk("R6 exempt tier silent", 1, 1, 0, 1, (1 << bp(0,0)) | (1 << bp(1,0)));

        // R6: disabling a threshold at run time
        por();
        en_tab[4][2] = 1'b0;
        samp(4, 200);
        chk("R6 disabled off tier", 1, 1, 0, 1,
            (1 << bp(0,4)) | (1 << bp(1,4)));
        en_tab[4][2] = 1'b1;

        // R2: throttle held until every sensor is below
        por();
        samp(0, 621);
        chk("R2 first hot", 1, 0, 0, 0, 1 << bp(0,0));
        samp(4, 95);
        chk("R2 two hot", 1, 0, 0, 0, (1 << bp(0,0)) | (1 << bp(0,4)));
        samp(0, 100);
        chk("R2 one still hot", 1, 0, 0, 0, (1 << bp(0,0)) | (1 << bp(0,4)));
        samp(4, 91);
        chk("R2 release, R8 sticky map", 0, 0, 0, 0,
            (1 << bp(0,0)) | (1 << bp(0,4)));

        // R3: clock stop latch, trip pulse, host release
        por();
        samp(3, 110);
        chk("R3 stop entry", 1, 1, 0, 1, 1 << bp(1,3));
        @(negedge clk);
        chk("R3 trip single cycle", 1, 1, 0, 0, 1 << bp(1,3));
        samp(3, 20);
        chk("R3 held after cool sample", 1, 1, 0, 0, 1 << bp(1,3));
        hreset();
        chk("R3 host release, R8 cleared", 0, 0, 0, 0, '0);

        // R9: no reaction on the capture edge; simultaneous strobes
        por();
        @(negedge clk);
        rd_value[0*W +: W] = 16'd621; rd_value[5*W +: W] = 16'd85;
        rd_valid = 6'b100001;
        @(negedge clk);
        rd_valid = '0;
        chk("R9 capture edge only", 0, 0, 0, 0, '0);
        @(negedge clk);
        chk("R9 next edge stop", 1, 1, 0, 1, (1 << bp(0,0)) | (1 << bp(1,5)));

        // R5: stop then power off, off dominates with no trip
        samp(5, 90);
        chk("R5 off over stop", 1, 1, 1, 0,
            (1 << bp(0,0)) | (1 << bp(1,5)) | (1 << bp(2,5)));

        // R4: power off ignores host reset and cooling; only rst_n clears
        por();
        samp(2, 60000);
        chk("R4 off entry no trip", 1, 1, 1, 0,
            (1 << bp(0,2)) | (1 << bp(2,2)));
        hreset();
        chk("R4 host reset ignored, R8 kept", 1, 1, 1, 0,
            (1 << bp(0,2)) | (1 << bp(2,2)));
        samp(2, 100);
        chk("R4 held after cool sample", 1, 1, 1, 0,
            (1 << bp(0,2)) | (1 << bp(2,2)));
        por();
        chk("R4 cleared by power-on reset", 0, 0, 0, 0, '0);

        // R7: host reset forgets stored samples
        samp(0, 700);
        hreset();
        chk("R7 samples cleared by host reset", 0, 0, 0, 0, '0);
        repeat (3) @(negedge clk);
        chk("R7 no retrigger without strobe", 0, 0, 0, 0, '0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule